// File: doc/BRIEF.md
# Reference clock validity monitor

This block decides whether an incoming reference clock is good enough to steer a local tuned oscillator. It samples the reference in the local clock domain and counts both of its transitions. It then measures how many local cycles one scaled reference period takes. A scaled period is the reference period multiplied by the ratio chosen on a two-bit select. Each measurement is compared against a programmable inclusive window that represents the oscillator's capture range.

The active-high `ref_ok` flag drops quickly when a measurement falls outside the window. This covers a reference that runs too fast, one that drifts too slow, and one that stops outright. A slow or stopped reference is caught as soon as the running count passes the upper limit, without waiting for the next transition. The flag is raised again only after a long unbroken run of good measurements. Select code 11 is bypass, and in bypass the monitor sits idle with its flag low.

The block has no data stream, so every pin is a plain level or clock.

Top module: `refmon_top`

## Requirements
- R1: After reset `ref_ok` is low. It rises only after 12 consecutive in-range scaled periods have been measured, counted from the first synchronized reference transition. It becomes visible 4 local cycles after the reference transition that closes the 12th window.
- R2: One scaled period spans a number of reference transitions, with both rising and falling transitions counted. Select 00 (ratio 1/2) uses 1 transition, select 01 (ratio 2) uses 4 and select 10 (ratio 6) uses 12.
- R3: A measured scaled period of N local cycles is in range when `lim_lo` <= N <= `lim_hi`, both bounds inclusive.
- R4: A scaled period shorter than `lim_lo` drops `ref_ok`, visible 4 local cycles after the transition that closes it.
- R5: A measurement whose count passes `lim_hi` is declared out of range at once, without waiting for a transition. After the last transition of a stopped reference, `ref_ok` is low within `lim_hi` + 6 local cycles.
- R6: Any out-of-range measurement clears the run of good measurements. A further 12 consecutive good ones are needed before `ref_ok` rises.
- R7: Select 11 (bypass) forces `ref_ok` low on the next cycle and clears all measurement state. After leaving bypass, the full recovery of R1 is required again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local crystal-derived clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Selected reference clock, asynchronous to `clk` |
| ratio_sel | input | 2 | Ratio select: 00 = 1/2, 01 = 2, 10 = 6, 11 = bypass |
| lim_lo | input | CNT_W | Lowest in-range scaled period, in local cycles |
| lim_hi | input | CNT_W | Highest in-range scaled period, in local cycles |
| ref_ok | output | 1 | High while the reference is judged valid |

## Verification
The bench sweeps every non-bypass select against reference half-periods from 2 to 8 local cycles. Half-periods of 4 and 6 land just outside and exactly on the window bounds, so a design that mapped a select to the wrong transition count, or made a bound exclusive, would report the wrong flag. Recovery is probed one window before and just after the 12th good measurement. A single short window is placed in the middle of a good run: a design that never reset its run count would raise the flag too early. A stopped reference and a bypass excursion catch an overrun that waits for a transition that never comes, and a bypass exit that keeps stale state.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  typedef enum logic [1:0] {
    RATIO_HALF   = 2'b00,
    RATIO_X2     = 2'b01,
    RATIO_X6     = 2'b10,
    RATIO_BYPASS = 2'b11
  } ratio_e;

  localparam int unsigned EDGE_W = 4;

  // Reference transitions (both polarities) per scaled period.
  function automatic logic [EDGE_W-1:0] edges_per_window(input ratio_e r);
    case (r)
      RATIO_HALF: return EDGE_W'(1);
      RATIO_X2:   return EDGE_W'(4);
      RATIO_X6:   return EDGE_W'(12);
      default:    return EDGE_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_p
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its delayed copy
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign edge_p = pipe[STAGES] ^ pipe[STAGES-1];

endmodule

// File: rtl/refmon_meter.sv
module refmon_meter
  import refmon_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             edge_p,
  input  logic [EDGE_W-1:0] edges_needed,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  output logic             win_done,
  output logic             win_good
);
  logic              armed;
  logic [CNT_W-1:0]  cyc;
  logic [EDGE_W-1:0] ecnt;
  logic [EDGE_W:0]   ecnt_nx;
  logic              last_edge;
  logic              overrun;

  assign ecnt_nx   = {1'b0, ecnt} + (EDGE_W+1)'(1);
  assign last_edge = ecnt_nx >= {1'b0, edges_needed};
  assign overrun   = armed && (cyc > lim_hi);

  always_ff @(posedge clk) begin
    if (!rst_n || idle) begin
      armed    <= 1'b0;
      cyc      <= '0;
      ecnt     <= '0;
      win_done <= 1'b0;
      win_good <= 1'b0;
    end else begin
      win_done <= 1'b0;
      win_good <= 1'b0;
      if (edge_p) begin
        if (!armed) begin
          armed <= 1'b1;
          cyc   <= CNT_W'(1);
          ecnt  <= '0;
        end else if (last_edge) begin
          win_done <= 1'b1;
          win_good <= (cyc >= lim_lo) && (cyc <= lim_hi);
          cyc      <= CNT_W'(1);
          ecnt     <= '0;
        end else begin
          ecnt <= ecnt_nx[EDGE_W-1:0];
          if (cyc != '1) cyc <= cyc + CNT_W'(1);
        end
      end else if (overrun) begin
        win_done <= 1'b1;
        win_good <= 1'b0;
        armed    <= 1'b0;
        cyc      <= '0;
        ecnt     <= '0;
      end else if (armed && cyc != '1) begin
        cyc <= cyc + CNT_W'(1);
      end
    end
  end

  // A count past the upper bound must be reported as a bad window next cycle
  assert_overrun_reported_R5: assert property (@(posedge clk) disable iff (!rst_n || idle)
    (armed && (cyc > lim_hi)) |=> (win_done && !win_good));

endmodule

// File: rtl/refmon_qual.sv
module refmon_qual #(
  parameter int unsigned GOOD_WINDOWS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic win_done,
  input  logic win_good,
  output logic flag
);
  localparam int unsigned STREAK_W = $clog2(GOOD_WINDOWS + 1);
  localparam logic [STREAK_W-1:0] STREAK_TOP = STREAK_W'(GOOD_WINDOWS - 1);

  logic [STREAK_W-1:0] streak;

  always_ff @(posedge clk) begin
    if (!rst_n || idle) begin
      streak <= '0;
      flag   <= 1'b0;
    end else if (win_done) begin
      if (!win_good) begin
        streak <= '0;
        flag   <= 1'b0;
      end else if (streak == STREAK_TOP) begin
        flag <= 1'b1;
      end else begin
        streak <= streak + STREAK_W'(1);
      end
    end
  end

  assert_rise_on_good_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(win_done && win_good));

  assert_bad_drops_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !win_good) |=> !flag);

  assert_flag_needs_full_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (streak == STREAK_TOP));

  assert_bypass_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !flag);

endmodule

// File: rtl/refmon_top.sv
module refmon_top
  import refmon_pkg::*;
#(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned GOOD_WINDOWS = 12,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic [1:0]       ratio_sel,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  output logic             ref_ok
);
  logic              idle;
  logic              edge_p;
  logic              win_done;
  logic              win_good;
  logic [EDGE_W-1:0] edges_needed;

  assign idle         = (ratio_e'(ratio_sel) == RATIO_BYPASS);
  assign edges_needed = edges_per_window(ratio_e'(ratio_sel));

  refmon_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ref_clk),
    .edge_p   (edge_p)
  );

  refmon_meter #(.CNT_W(CNT_W)) meter_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle         (idle),
    .edge_p       (edge_p),
    .edges_needed (edges_needed),
    .lim_lo       (lim_lo),
    .lim_hi       (lim_hi),
    .win_done     (win_done),
    .win_good     (win_good)
  );

  refmon_qual #(.GOOD_WINDOWS(GOOD_WINDOWS)) qual_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (idle),
    .win_done (win_done),
    .win_good (win_good),
    .flag     (ref_ok)
  );

endmodule

// File: tb/refmon_top_tb_top.sv
module refmon_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic [1:0]  ratio_sel = 2'b00;
  logic [15:0] lim_lo = 16'd5;
  logic [15:0] lim_hi = 16'd6;
  logic        ref_ok;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  refmon_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ratio_sel(ratio_sel),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .ref_ok(ref_ok)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (ref_ok !== exp) begin
      errors++;
      $display("FAIL %s ref_ok actual %b expected %b at %0t", req, ref_ok, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic half(input int h);
    repeat (h) @(negedge clk);
    ref_clk = ~ref_clk;
  endtask

  function automatic int eps_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : 12;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state
    do_reset();
    chk("R1 reset", 1'b0);

    // R1 recovery timing and R5 stop, select 01 (4 transitions per window)
    ratio_sel = 2'b01; lim_lo = 16'd17; lim_hi = 16'd24;
    do_reset();
    for (int i = 0; i < 48; i++) half(5);   // arm + 11 full windows + 3 edges
    repeat (5) @(negedge clk);
    chk("R1 not before 12 windows", 1'b0);
    ref_clk = ~ref_clk;                     // closes 12th window
    repeat (5) @(negedge clk);
    chk("R1 raised after 12 windows", 1'b1);
    repeat (25) @(negedge clk);             // lim_hi + 6 after last transition
    chk("R5 stopped reference", 1'b0);

    // R6 run restart, R4 short window, select 00
    ratio_sel = 2'b00; lim_lo = 16'd5; lim_hi = 16'd6;
    do_reset();
    half(5);                                // arm
    for (int i = 0; i < 11; i++) half(5);
    half(2);                                // short window
    for (int i = 0; i < 11; i++) half(5);
    repeat (5) @(negedge clk);
    chk("R6 11 good after bad", 1'b0);
    ref_clk = ~ref_clk;
    repeat (6) @(negedge clk);
    chk("R6 12 good after bad", 1'b1);
    ref_clk = ~ref_clk;                     // interval 6, on the upper bound
    half(5); half(5);
    chk("R3 upper bound keeps flag", 1'b1);
    half(2);
    repeat (5) @(negedge clk);
    chk("R4 short window drops", 1'b0);

    // R7 bypass
    do_reset();
    for (int i = 0; i < 14; i++) half(5);
    chk("R7 high before bypass", 1'b1);
    ratio_sel = 2'b11;
    repeat (2) @(negedge clk);
    chk("R7 bypass forces low", 1'b0);
    for (int i = 0; i < 20; i++) half(5);
    chk("R7 bypass stays low", 1'b0);
    ratio_sel = 2'b00;
    for (int i = 0; i < 12; i++) half(5);
    chk("R7 no early recovery after bypass", 1'b0);
    half(5); half(5);
    chk("R7 recovery after bypass", 1'b1);

    // R2/R3 sweep over select and half-period
    for (int s = 0; s < 3; s++) begin
      for (int h = 2; h <= 8; h++) begin
        int e;
        logic exp;
        e = eps_of(s);
        ratio_sel = 2'(s);
        lim_lo = 16'(4 * e + 1);
        lim_hi = 16'(6 * e);
        do_reset();
        for (int i = 0; i < 2 + 14 * e; i++) half(h);
        repeat (2) @(negedge clk);
        exp = ((4 * e + 1) <= e * h) && (e * h <= 6 * e);
        chk($sformatf("R2 R3 sweep sel %0d half %0d", s, h), exp);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule